// File: doc/BRIEF.md
# Disc Player Transport Mode Controller

This block is the transport arbiter of a disc player. It takes one-cycle command strobes from decoded keys and remote codes (play/pause, stop, next, previous, repeat, program, clear, random), two held search levels, an end-of-track strobe and the disc's track count. From these it keeps the transport state, the target track, the repeat setting and the program and random flags. It also raises a one-cycle seek request each time the mechanism has to move to a new or restarted track. The play list of up to 16 programmed tracks and the pseudo-random track chooser are both inside the block.

States are STOP (code 0), PLAY (1), PAUSE (2), SCAN_FWD (3) and SCAN_REV (4). The transitions are:
- STOP to PLAY on play.
- PLAY and PAUSE toggle on play.
- Any state goes to STOP on stop.
- PLAY goes to SCAN_FWD or SCAN_REV while the matching search level is held, and back to PLAY when it is released.
- PLAY goes to STOP at end-of-track when nothing is left to play.

A track change during PLAY or PAUSE comes from next, previous or end-of-track. The choice among program order, random draw, repeat and linear order is made in that transition. Commands that arrive while the block is in STOP with no disc present are dropped.

Every output is registered. A command sampled at a clock edge shows up on the outputs just after that edge.

Top module: `xport_ctrl`

## Requirements
- R1: After reset the state is STOP (0), the target track is 1, repeat is off (0), the program, full, random and seek outputs are low.
- R2: Play in STOP enters PLAY and pulses seek_req_o for one cycle. Play toggles between PLAY and PAUSE without a seek.
- R3: Stop puts the state in STOP on the next cycle from any state and ends program playback.
- R4: Next and previous step the target by one, with next wrapping from the track count to 1 and previous wrapping from 1 to the track count. In PLAY or PAUSE each step pulses seek_req_o.
- R5: In PLAY or PAUSE, previous with elapsed_s below 2 moves to the prior track. With elapsed_s of 2 or more it keeps the same target and pulses seek_req_o to restart that track.
- R6: In PLAY a held scan_fwd gives SCAN_FWD (3) and a held scan_rev gives SCAN_REV (4). On release the state returns to PLAY with the target set to cur_trk. Stop during a search gives STOP.
- R7: Each repeat command steps the repeat setting off (0), then one track (1), then whole disc (2), then back to off.
- R8: End-of-track in PLAY behaves as follows. Repeat-one replays the same target with a seek. Otherwise the target advances by one with a seek. After the last track it wraps to 1 under repeat-all, or goes to STOP when repeat is off.
- R9: The first program command in STOP sets program mode. Each further program command in STOP appends the target to the list. Play then plays the entries in stored order. End-of-track after the last entry goes to STOP when repeat is off.
- R10: The list holds 16 entries. prog_full_o rises when the 16th entry is stored, and later program commands store nothing, so playback ends after the 16th entry.
- R11: Clear empties the list, leaves program mode and ends program playback, so the next end-of-track follows linear order.
- R12: Random mode toggles on the random command. Play and each end-of-track then give a target in 1..track count, drawn from a free-running 16-bit LFSR (out-of-range draws are skipped on later cycles), with a seek. End-of-track in random mode never stops play.
- R13: In STOP with disc_present low, every command is ignored. State, target, repeat, program and random outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_present | input | 1 | A disc is loaded |
| cmd_play | input | 1 | Play/pause strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_next | input | 1 | Next-track strobe |
| cmd_prev | input | 1 | Previous-track strobe |
| cmd_repeat | input | 1 | Repeat-cycle strobe |
| cmd_prog | input | 1 | Program enter/store strobe |
| cmd_clear | input | 1 | Program clear strobe |
| cmd_random | input | 1 | Random toggle strobe |
| scan_fwd | input | 1 | Forward search, held |
| scan_rev | input | 1 | Reverse search, held |
| eot | input | 1 | End-of-track strobe |
| trk_cnt | input | TW | Number of tracks on the disc |
| cur_trk | input | TW | Track currently under the pickup |
| elapsed_s | input | SEC_W | Seconds played in the current track |
| state_o | output | 3 | Transport state code |
| target_o | output | TW | Target track |
| repeat_o | output | 2 | Repeat setting |
| prog_mode_o | output | 1 | Program mode active |
| prog_play_o | output | 1 | Playing from the program list |
| prog_full_o | output | 1 | Program list full |
| random_o | output | 1 | Random mode active |
| seek_req_o | output | 1 | One-cycle seek request |

## Verification
Every output has a single register between a command and the port. State, target, repeat, flags and the seek pulse are therefore due in the first cycle after the edge that samples the strobe. The bench drives each strobe on a falling edge, holds it for one cycle, and samples on the next falling edge. That is exactly the point at which the result must be present, and seek_req_o must show its single-cycle pulse there. Held search levels follow the same rule, one cycle after each level change. The random target is checked only against its allowed range, because the draw order is not part of the requirements.

// File: rtl/xport_pkg.sv
package xport_pkg;

    typedef enum logic [2:0] {
        XS_STOP     = 3'd0,
        XS_PLAY     = 3'd1,
        XS_PAUSE    = 3'd2,
        XS_SCAN_FWD = 3'd3,
        XS_SCAN_REV = 3'd4
    } xport_state_e;

    typedef enum logic [1:0] {
        RP_OFF = 2'd0,
        RP_ONE = 2'd1,
        RP_ALL = 2'd2
    } repeat_e;

endpackage

// File: rtl/xport_prog_list.sv
module xport_prog_list #(
    parameter int DEPTH = 16,
    parameter int TW    = 7,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_trk,
    input  logic          clr,
    input  logic [IW-1:0] rd_idx,
    output logic [TW-1:0] rd_trk,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [TW-1:0] slots [DEPTH];

    assign full   = (count == CW'(DEPTH));
    assign rd_trk = slots[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             count <= '0;
        else if (clr)           count <= '0;
        else if (wr_en && !full) count <= count + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full && !clr) slots[IW'(count)] <= wr_trk;
    end
endmodule

// File: rtl/xport_rand_pick.sv
module xport_rand_pick #(
    parameter int                TW     = 7,
    parameter int                LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] trk_cnt,
    output logic [TW-1:0] pick
);
    logic [LFSR_W-1:0] lfsr;
    logic [TW-1:0]     mask;
    logic [TW-1:0]     cand;

    always_comb begin
        for (int i = 0; i < TW; i++) mask[i] = (trk_cnt >> i) != '0;
        cand = lfsr[TW-1:0] & mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr <= SEED;
            pick <= TW'(1);
        end else begin
            lfsr <= lfsr[0] ? ((lfsr >> 1) ^ TAPS) : (lfsr >> 1);
            if (cand != '0 && cand <= trk_cnt) pick <= cand;
        end
    end
endmodule

// File: rtl/xport_ctrl.sv
module xport_ctrl
    import xport_pkg::*;
#(
    parameter int TW         = 7,
    parameter int PROG_DEPTH = 16,
    parameter int PREV_WIN_S = 2,
    parameter int SEC_W      = 8,
    localparam int IW        = $clog2(PROG_DEPTH),
    localparam int CW        = $clog2(PROG_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disc_present,
    input  logic             cmd_play,
    input  logic             cmd_stop,
    input  logic             cmd_next,
    input  logic             cmd_prev,
    input  logic             cmd_repeat,
    input  logic             cmd_prog,
    input  logic             cmd_clear,
    input  logic             cmd_random,
    input  logic             scan_fwd,
    input  logic             scan_rev,
    input  logic             eot,
    input  logic [TW-1:0]    trk_cnt,
    input  logic [TW-1:0]    cur_trk,
    input  logic [SEC_W-1:0] elapsed_s,
    output logic [2:0]       state_o,
    output logic [TW-1:0]    target_o,
    output logic [1:0]       repeat_o,
    output logic             prog_mode_o,
    output logic             prog_play_o,
    output logic             prog_full_o,
    output logic             random_o,
    output logic             seek_req_o
);
    xport_state_e  state_q, state_d;
    repeat_e       rpt_q, rpt_d;
    logic [TW-1:0] tgt_q, tgt_d;
    logic [IW-1:0] idx_q, idx_d, rd_idx, idx_fwd, idx_back;
    logic          pmode_q, pmode_d, pplay_q, pplay_d, rnd_q, rnd_d, seek_d;
    logic          wr_en, clr, accept, early, list_last;
    logic [TW-1:0] rd_trk, pick, tgt_inc, tgt_dec;
    logic [CW-1:0] p_count;

    xport_prog_list #(.DEPTH(PROG_DEPTH), .TW(TW)) u_list (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_trk(tgt_q), .clr(clr),
        .rd_idx(rd_idx), .rd_trk(rd_trk), .count(p_count), .full(prog_full_o)
    );

    xport_rand_pick #(.TW(TW)) u_rand (
        .clk(clk), .rst_n(rst_n), .trk_cnt(trk_cnt), .pick(pick)
    );

    // Neighbour computations: list index and linear track stepping.
    always_comb begin
        list_last = (CW'(idx_q) + CW'(1)) >= p_count;
        idx_fwd   = list_last ? '0 : idx_q + IW'(1);
        idx_back  = (idx_q == '0) ? IW'(p_count - CW'(1)) : idx_q - IW'(1);
        early     = elapsed_s < SEC_W'(PREV_WIN_S);
        tgt_inc   = (tgt_q >= trk_cnt) ? TW'(1) : tgt_q + TW'(1);
        tgt_dec   = (tgt_q <= TW'(1)) ? trk_cnt : tgt_q - TW'(1);
        if (state_q == XS_STOP)    rd_idx = '0;
        else if (cmd_prev && early) rd_idx = idx_back;
        else                        rd_idx = idx_fwd;
    end

    // Next-state and next-output logic.
    always_comb begin
        state_d = state_q; rpt_d = rpt_q; tgt_d = tgt_q; idx_d = idx_q;
        pmode_d = pmode_q; pplay_d = pplay_q; rnd_d = rnd_q;
        seek_d  = 1'b0; wr_en = 1'b0; clr = 1'b0;
        accept  = !(state_q == XS_STOP && !disc_present);
        if (accept) begin
            if (cmd_repeat) begin
                unique case (rpt_q)
                    RP_OFF:  rpt_d = RP_ONE;
                    RP_ONE:  rpt_d = RP_ALL;
                    default: rpt_d = RP_OFF;
                endcase
            end
            if (cmd_random) rnd_d = !rnd_q;
            unique case (state_q)
                XS_STOP: begin
                    if (cmd_play) begin
                        state_d = XS_PLAY;
                        seek_d  = 1'b1;
                        if (pmode_q && p_count != '0 && !cmd_clear) begin
                            pplay_d = 1'b1; idx_d = '0; tgt_d = rd_trk;
                        end else if (rnd_q) begin
                            tgt_d = pick;
                        end
                    end else if (cmd_next) tgt_d = tgt_inc;
                    else if (cmd_prev)     tgt_d = tgt_dec;
                    if (cmd_prog && !cmd_clear) begin
                        if (!pmode_q) pmode_d = 1'b1;
                        else          wr_en   = 1'b1;
                    end
                end
                XS_PLAY, XS_PAUSE: begin
                    if (cmd_stop) begin
                        state_d = XS_STOP; pplay_d = 1'b0;
                    end else begin
                        if (cmd_play) state_d = (state_q == XS_PLAY) ? XS_PAUSE : XS_PLAY;
                        else if (state_q == XS_PLAY && scan_fwd) state_d = XS_SCAN_FWD;
                        else if (state_q == XS_PLAY && scan_rev) state_d = XS_SCAN_REV;
                        if (cmd_prev) begin
                            seek_d = 1'b1;
                            if (early) begin
                                if (pplay_q)     begin idx_d = idx_back; tgt_d = rd_trk; end
                                else if (!rnd_q) tgt_d = tgt_dec;
                            end
                        end else if (cmd_next) begin
                            seek_d = 1'b1;
                            if (pplay_q)    begin idx_d = idx_fwd; tgt_d = rd_trk; end
                            else if (rnd_q) tgt_d = pick;
                            else            tgt_d = tgt_inc;
                        end else if (eot && state_q == XS_PLAY && !cmd_play) begin
                            if (rpt_q == RP_ONE) seek_d = 1'b1;
                            else if (pplay_q) begin
                                if (!list_last || rpt_q == RP_ALL) begin
                                    idx_d = idx_fwd; tgt_d = rd_trk; seek_d = 1'b1;
                                end else begin
                                    state_d = XS_STOP; pplay_d = 1'b0;
                                end
                            end else if (rnd_q) begin
                                tgt_d = pick; seek_d = 1'b1;
                            end else if (tgt_q < trk_cnt || rpt_q == RP_ALL) begin
                                tgt_d = tgt_inc; seek_d = 1'b1;
                            end else begin
                                state_d = XS_STOP;
                            end
                        end
                    end
                end
                XS_SCAN_FWD, XS_SCAN_REV: begin
                    if (cmd_stop) begin
                        state_d = XS_STOP; pplay_d = 1'b0;
                    end else if ((state_q == XS_SCAN_FWD && !scan_fwd) ||
                                 (state_q == XS_SCAN_REV && !scan_rev)) begin
                        state_d = XS_PLAY; tgt_d = cur_trk;
                    end
                end
                default: state_d = XS_STOP;
            endcase
            if (cmd_clear) begin
                clr = 1'b1; pmode_d = 1'b0; pplay_d = 1'b0;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_STOP;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_q <= RP_OFF; tgt_q <= TW'(1); idx_q <= '0;
            pmode_q <= 1'b0; pplay_q <= 1'b0; rnd_q <= 1'b0; seek_req_o <= 1'b0;
        end else begin
            rpt_q <= rpt_d; tgt_q <= tgt_d; idx_q <= idx_d;
            pmode_q <= pmode_d; pplay_q <= pplay_d; rnd_q <= rnd_d; seek_req_o <= seek_d;
        end
    end

    assign state_o     = state_q;
    assign target_o    = tgt_q;
    assign repeat_o    = rpt_q;
    assign prog_mode_o = pmode_q;
    assign prog_play_o = pplay_q;
    assign random_o    = rnd_q;
endmodule

// File: rtl/xport_ctrl_chk.sv
module xport_ctrl_chk #(
    parameter int TW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          disc_present,
    input logic          cmd_play,
    input logic          cmd_stop,
    input logic          cmd_repeat,
    input logic          cmd_clear,
    input logic          scan_fwd,
    input logic          scan_rev,
    input logic          eot,
    input logic [TW-1:0] trk_cnt,
    input logic [2:0]    state_o,
    input logic [TW-1:0] target_o,
    input logic [1:0]    repeat_o,
    input logic          prog_mode_o,
    input logic          prog_play_o,
    input logic          prog_full_o,
    input logic          random_o,
    input logic          seek_req_o
);
    logic blocked;
    assign blocked = (state_o == 3'd0) && !disc_present;

    a_r3_stop_any: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> state_o == 3'd0);

    a_r13_no_disc: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> (state_o == 3'd0 && $stable(target_o) && $stable(repeat_o)
                     && $stable(prog_mode_o) && $stable(random_o)));

    a_r7_repeat_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_repeat && !blocked) |=> repeat_o != $past(repeat_o));

    a_r7_repeat_legal: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_o != 2'd3);

    a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_full_o && !cmd_clear) |=> prog_full_o);

    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear && !blocked) |=> (!prog_mode_o && !prog_full_o && !prog_play_o));

    a_r4_seek_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req_o |-> (target_o >= TW'(1) && target_o <= trk_cnt));

    a_r12_random_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (random_o && !prog_play_o && state_o == 3'd1 && eot && !cmd_stop
         && !cmd_play && !scan_fwd && !scan_rev) |=> state_o == 3'd1);
endmodule

bind xport_ctrl xport_ctrl_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .disc_present(disc_present), .cmd_play(cmd_play),
    .cmd_stop(cmd_stop), .cmd_repeat(cmd_repeat), .cmd_clear(cmd_clear),
    .scan_fwd(scan_fwd), .scan_rev(scan_rev), .eot(eot), .trk_cnt(trk_cnt),
    .state_o(state_o), .target_o(target_o), .repeat_o(repeat_o),
    .prog_mode_o(prog_mode_o), .prog_play_o(prog_play_o), .prog_full_o(prog_full_o),
    .random_o(random_o), .seek_req_o(seek_req_o)
);

// File: tb/tb_xport_ctrl.sv
module tb_xport_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 7;
    localparam int WATCHDOG = 20000;
    // ops: 0 nop,1 play,2 stop,3 next,4 prev,5 repeat,6 prog,7 clear,8 random,9 eot
    localparam int NV = 22;
    localparam logic [14:0] VEC [NV] = '{
        {4'd3, 3'd0, 7'd2, 1'b0}, {4'd3, 3'd0, 7'd3, 1'b0},
        {4'd4, 3'd0, 7'd2, 1'b0}, {4'd4, 3'd0, 7'd1, 1'b0},
        {4'd4, 3'd0, 7'd5, 1'b0}, {4'd3, 3'd0, 7'd1, 1'b0},
        {4'd1, 3'd1, 7'd1, 1'b1}, {4'd1, 3'd2, 7'd1, 1'b0},
        {4'd1, 3'd1, 7'd1, 1'b0}, {4'd3, 3'd1, 7'd2, 1'b1},
        {4'd4, 3'd1, 7'd2, 1'b1}, {4'd9, 3'd1, 7'd3, 1'b1},
        {4'd9, 3'd1, 7'd4, 1'b1}, {4'd9, 3'd1, 7'd5, 1'b1},
        {4'd9, 3'd0, 7'd5, 1'b0}, {4'd5, 3'd0, 7'd5, 1'b0},
        {4'd1, 3'd1, 7'd5, 1'b1}, {4'd9, 3'd1, 7'd5, 1'b1},
        {4'd5, 3'd1, 7'd5, 1'b0}, {4'd9, 3'd1, 7'd1, 1'b1},
        {4'd5, 3'd1, 7'd1, 1'b0}, {4'd2, 3'd0, 7'd1, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, disc_present = 1'b1;
    logic cmd_play = 0, cmd_stop = 0, cmd_next = 0, cmd_prev = 0, cmd_repeat = 0;
    logic cmd_prog = 0, cmd_clear = 0, cmd_random = 0, scan_fwd = 0, scan_rev = 0, eot = 0;
    logic [TW-1:0] trk_cnt = 7'd5, cur_trk = 7'd1;
    logic [7:0] elapsed_s = 8'd10;
    logic [2:0] state_o;
    logic [TW-1:0] target_o;
    logic [1:0] repeat_o;
    logic prog_mode_o, prog_play_o, prog_full_o, random_o, seek_req_o;
    int n_chk = 0, n_bad = 0;
    int saved;

    always #(CLK_PERIOD/2) clk = ~clk;

    xport_ctrl dut (
        .clk(clk), .rst_n(rst_n), .disc_present(disc_present), .cmd_play(cmd_play),
        .cmd_stop(cmd_stop), .cmd_next(cmd_next), .cmd_prev(cmd_prev),
        .cmd_repeat(cmd_repeat), .cmd_prog(cmd_prog), .cmd_clear(cmd_clear),
        .cmd_random(cmd_random), .scan_fwd(scan_fwd), .scan_rev(scan_rev), .eot(eot),
        .trk_cnt(trk_cnt), .cur_trk(cur_trk), .elapsed_s(elapsed_s),
        .state_o(state_o), .target_o(target_o), .repeat_o(repeat_o),
        .prog_mode_o(prog_mode_o), .prog_play_o(prog_play_o), .prog_full_o(prog_full_o),
        .random_o(random_o), .seek_req_o(seek_req_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic op(input int code);
        @(negedge clk);
        case (code)
            1: cmd_play = 1;   2: cmd_stop = 1;   3: cmd_next = 1;
            4: cmd_prev = 1;   5: cmd_repeat = 1; 6: cmd_prog = 1;
            7: cmd_clear = 1;  8: cmd_random = 1; 9: eot = 1;
            default: ;
        endcase
        @(negedge clk);
        {cmd_play, cmd_stop, cmd_next, cmd_prev, cmd_repeat} = '0;
        {cmd_prog, cmd_clear, cmd_random, eot} = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 state", state_o, 0);   check("R1 target", target_o, 1);
        check("R1 repeat", repeat_o, 0); check("R1 prog", prog_mode_o, 0);
        check("R1 full", prog_full_o, 0); check("R1 random", random_o, 0);
        check("R1 seek", seek_req_o, 0);
        rst_n = 1;

        // R2 R4 R5 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            op(int'(VEC[i][14:11]));
            check($sformatf("R2/R4/R8 vec%0d state", i), state_o, int'(VEC[i][10:8]));
            check($sformatf("R4/R8 vec%0d target", i), target_o, int'(VEC[i][7:1]));
            check($sformatf("R2/R4 vec%0d seek", i), seek_req_o, int'(VEC[i][0]));
        end

        // R7 repeat cycle
        op(5); check("R7 one", repeat_o, 1);
        op(5); check("R7 all", repeat_o, 2);
        op(5); check("R7 off", repeat_o, 0);

        // R5 previous window
        op(3); op(3); op(1);
        check("R5 start", target_o, 3);
        elapsed_s = 8'd1; op(4);
        check("R5 early prev", target_o, 2); check("R5 early seek", seek_req_o, 1);
        elapsed_s = 8'd2; op(4);
        check("R5 restart", target_o, 2); check("R5 restart seek", seek_req_o, 1);
        elapsed_s = 8'd10;

        // R6 search
        @(negedge clk); scan_fwd = 1; @(negedge clk);
        check("R6 fwd", state_o, 3);
        cur_trk = 7'd4; scan_fwd = 0; @(negedge clk);
        check("R6 back to play", state_o, 1); check("R6 target", target_o, 4);
        scan_rev = 1; @(negedge clk);
        check("R6 rev", state_o, 4);
        op(2); check("R6 R3 stop in search", state_o, 0);
        scan_rev = 0;

        // R9 program play
        op(6); check("R9 mode", prog_mode_o, 1);
        op(4); op(4); op(6);
        op(3); op(3); op(6);
        op(4); op(4); op(4); op(6);
        op(1); check("R9 first", target_o, 2); check("R9 pplay", prog_play_o, 1);
        op(9); check("R9 second", target_o, 4);
        op(9); check("R9 third", target_o, 1);
        op(9); check("R9 end stop", state_o, 0);

        // R10 full list
        op(7); op(6);
        for (int k = 0; k < 17; k++) begin
            op(6);
            if (k == 14) check("R10 not full at 15", prog_full_o, 0);
            if (k == 15) check("R10 full at 16", prog_full_o, 1);
            op(3);
        end
        check("R10 still full", prog_full_o, 1);
        op(1); check("R10 entry0", target_o, 1);
        for (int k = 1; k < 16; k++) begin
            op(9); check("R10 entry", target_o, (k % 5) + 1);
        end
        op(9); check("R10 stops after 16", state_o, 0);

        // R11 clear
        op(7); check("R11 mode off", prog_mode_o, 0); check("R11 not full", prog_full_o, 0);
        op(1); check("R11 normal play", prog_play_o, 0); check("R11 target", target_o, 1);
        op(9); check("R11 linear eot", target_o, 2);
        op(2);

        // R12 random
        op(8); check("R12 random on", random_o, 1);
        op(1);
        check("R12 range", int'(target_o >= 1 && target_o <= 5), 1);
        check("R12 seek", seek_req_o, 1);
        for (int k = 0; k < 20; k++) begin
            op(9);
            check("R12 keeps playing", state_o, 1);
            check("R12 draw range", int'(target_o >= 1 && target_o <= 5), 1);
            check("R12 draw seek", seek_req_o, 1);
        end
        op(2); op(8); check("R12 random off", random_o, 0);

        // R13 no disc
        disc_present = 0; saved = target_o;
        op(1); check("R13 play ignored", state_o, 0);
        op(3); check("R13 next ignored", target_o, saved);
        op(5); check("R13 repeat ignored", repeat_o, 0);
        op(6); check("R13 prog ignored", prog_mode_o, 0);
        op(8); check("R13 random ignored", random_o, 0);
        disc_present = 1;

        // R3 stop from pause
        op(1); op(1); check("R2 pause", state_o, 2);
        op(2); check("R3 stop from pause", state_o, 0);

        summary();
    end
endmodule